// File: doc/BRIEF.md
# Prescaled Watchdog Reset Timer

This block guards a small 8-bit core against a program that has stopped running. Software arms it through one control register on the core's special-function bus and must then restart it again and again. If it does not, a count chain runs out and the block sends a single-cycle reset request to the chip's reset logic. The chain has two stages. A prescaler divides the core's tick by a power of two chosen by a three-bit select field. Its terminal count steps a main counter, which is 14 bits wide by default.

The control register holds four things: the arm bit, a restart bit that clears itself, a bit that says whether the timer keeps counting while the core is idle, and the select field. Turning the arm bit off or writing the restart bit clears both the prescaler and the main counter. When the main counter overflows, the request pulse fires and the block disarms itself. A new select value is held back until the prescaler period in progress has ended, so a period never ends early or late in the middle.

Top module: `wdt_sfr_watchdog`

## Requirements
- R1: After reset, and at once whenever `rst_n` goes low, the control register reads 0x00 and `wdt_rst_req` is low.
- R2: The register answers only at address `SFR_ADDR` (default 0x8F). Its read layout is: bit 7 = arm, bit 5 = idle-run, bits 2:0 = select. Bits 6, 4 and 3 always read 0. Reads at any other address return 0, and writes to any other address change nothing.
- R3: Select code k sets a prescaler ratio of 2^(k+1), so codes 0 to 7 give ratios 2 to 256. With a tick on every cycle, the request goes high exactly ratio × 2^CNT_W cycles after the clock edge that stores the arm bit.
- R4: `wdt_rst_req` is high for exactly one cycle. The same edge that raises it clears the arm bit. The idle-run bit and the select field keep their values.
- R5: Writing 1 to bit 6 together with arm = 1 restarts the timer. The restart bit acts for one cycle and then clears itself. During that cycle the prescaler and counter are cleared, so the next full period counts from the cycle that follows. Bit 6 reads 0.
- R6: While the arm bit is 0, the prescaler and counter stay at zero. Arming again starts a complete period.
- R7: When `core_idle` is high and the idle-run bit is 0, counting pauses. When the idle-run bit is 1, counting continues while the core is idle.
- R8: A cycle in which `tick` is low does not advance the count. The request is delayed by one cycle for each such cycle.
- R9: A write that changes the select field while the timer is armed takes effect only after the prescaler period in progress reaches its terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the core, one step per high cycle |
| core_idle | input | 1 | High while the core is in idle mode |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | ADDR_W | Register address, used for both read and write |
| sfr_wdata | input | DATA_W | Write data |
| sfr_rdata | output | DATA_W | Read data, combinational from the address |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with CNT_W = 4 and leaves the other parameters at their defaults. A period is then only ratio × 16 cycles long, so the bench can run every one of the eight select codes all the way to overflow, once with the core idle and idle-run set and once with the core active. Each case is timed exactly against ratio × 2^CNT_W. The short counter also brings the other timing cases within reach, each with an exact arithmetic expected cycle count: a restart, disarming and arming again, an idle pause, a tick gap, and a select change in the middle of a prescaler period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // control register bit positions (the select field sits at bit 0 upward)
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned CLR_BIT  = 6;
  localparam int unsigned IDLE_BIT = 5;
  localparam int unsigned SEL_LSB  = 0;

  // prescaler ratio for a select code: 2, 4, ..., 2^(code+1)
  function automatic int unsigned ratio_of(input int unsigned code);
    return 32'd2 << code;
  endfunction

  // prescaler terminal value for a select code
  function automatic int unsigned pre_last(input int unsigned code);
    return ratio_of(code) - 32'd1;
  endfunction

  // ticks from arming to overflow for a select code and counter width
  function automatic int unsigned period_of(input int unsigned code,
                                            input int unsigned cnt_w);
    return ratio_of(code) << cnt_w;
  endfunction

endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PS_W     = 3,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h8F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf,
  output logic              en_q,
  output logic              clr_q,
  output logic              idle_run_q,
  output logic [PS_W-1:0]   sel_q,
  output logic [PS_W-1:0]   sel_nxt,
  output logic [DATA_W-1:0] rdata
);
  import wdt_pkg::*;

  logic hit;
  logic wr_hit;
  logic unused_wbits;

  assign hit    = (addr == SFR_ADDR);
  assign wr_hit = wr & hit;

  // value the select field takes at the coming edge
  assign sel_nxt = wr_hit ? wdata[SEL_LSB +: PS_W] : sel_q;

  // bits that are not held in the register
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      clr_q      <= 1'b0;
      idle_run_q <= 1'b0;
      sel_q      <= '0;
    end else begin
      clr_q <= wr_hit & wdata[CLR_BIT];
      if (wr_hit) begin
        en_q       <= wdata[EN_BIT];
        idle_run_q <= wdata[IDLE_BIT];
        sel_q      <= wdata[SEL_LSB +: PS_W];
      end
      // an overflow disarms, ahead of a write at the same edge
      if (ovf) en_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[EN_BIT]             = en_q;
      rdata[IDLE_BIT]           = idle_run_q;
      rdata[SEL_LSB +: PS_W]    = sel_q;
    end
  end

  // R5: the restart bit lasts one cycle unless written again
  p_clr_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !(wr_hit && wdata[CLR_BIT])) |=> !clr_q);

  // R4: an overflow leaves the block disarmed
  p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !en_q);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PS_W  = 3,
  localparam int unsigned PRE_W = 1 << PS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [PS_W-1:0]  sel_q,
  input  logic [PS_W-1:0]  sel_nxt,
  output logic             tc,
  output logic [PRE_W-1:0] pre_cnt
);
  import wdt_pkg::*;

  logic [PS_W-1:0]  act_sel;
  logic [PRE_W-1:0] pre_cnt_q;
  logic [PRE_W-1:0] last_val;
  logic             at_last;

  assign last_val = PRE_W'(pre_last(int'(act_sel)));
  assign at_last  = (pre_cnt_q == last_val);
  assign tc       = step & ~clr & at_last;
  assign pre_cnt  = pre_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
      act_sel   <= '0;
    end else if (clr) begin
      pre_cnt_q <= '0;
      act_sel   <= sel_nxt;
    end else if (step) begin
      if (at_last) begin
        pre_cnt_q <= '0;
        act_sel   <= sel_q;
      end else begin
        pre_cnt_q <= pre_cnt_q + 1'b1;
      end
    end
  end

  // R3: the prescaler never passes the terminal value of its ratio
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt_q <= last_val);

  // R8: no step and no clear leaves the prescaler untouched
  p_pre_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> ($stable(pre_cnt_q) && $stable(act_sel)));

  // R9: the ratio in use changes only at a terminal count or a clear
  p_sel_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tc) |=> $stable(act_sel));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic ovf
);

  logic [CNT_W-1:0] cnt_q;

  assign ovf = inc & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + 1'b1;
  end

  // R6: a clear leaves the counter at zero
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R3: the counter only moves on a prescaler terminal count
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_sfr_watchdog.sv
module wdt_sfr_watchdog #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PS_W     = 3,
  parameter int unsigned CNT_W    = 14,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h8F,
  localparam int unsigned PRE_W   = 1 << PS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              core_idle,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              wdt_rst_req
);

  logic             en_q;
  logic             clr_q;
  logic             idle_run_q;
  logic [PS_W-1:0]  sel_q;
  logic [PS_W-1:0]  sel_nxt;
  logic             run;
  logic             clr_all;
  logic             step;
  logic             pre_tc;
  logic [PRE_W-1:0] pre_cnt;
  logic             cnt_ovf;
  logic             req_q;

  // named internal events
  assign run     = en_q & ~clr_q;
  assign clr_all = ~run;
  assign step    = run & tick & (~core_idle | idle_run_q);

  wdt_ctl_reg #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PS_W     (PS_W),
    .SFR_ADDR (SFR_ADDR)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (sfr_wr),
    .addr       (sfr_addr),
    .wdata      (sfr_wdata),
    .ovf        (cnt_ovf),
    .en_q       (en_q),
    .clr_q      (clr_q),
    .idle_run_q (idle_run_q),
    .sel_q      (sel_q),
    .sel_nxt    (sel_nxt),
    .rdata      (sfr_rdata)
  );

  wdt_prescaler #(
    .PS_W (PS_W)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_all),
    .step    (step),
    .sel_q   (sel_q),
    .sel_nxt (sel_nxt),
    .tc      (pre_tc),
    .pre_cnt (pre_cnt)
  );

  wdt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .inc   (pre_tc),
    .ovf   (cnt_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= cnt_ovf;
  end

  assign wdt_rst_req = req_q;

  // R4: the request never lasts two cycles
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  // R4: the request and the disarm come from the same edge
  p_req_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> !en_q);

  // R7: an idle core without idle-run freezes the prescaler
  p_idle_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && core_idle && !idle_run_q) |=> $stable(pre_cnt));

  // R6: disarmed means the prescaler reads zero one cycle later
  p_pre_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pre_cnt == '0));

endmodule

// File: tb/tb_wdt_sfr_watchdog.sv
module tb_wdt_sfr_watchdog;

  localparam int unsigned CNT_W = 4;
  localparam logic [7:0]  A_WDT = 8'h8F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       core_idle = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = A_WDT;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       wdt_rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int c = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_sfr_watchdog #(.CNT_W(CNT_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .core_idle   (core_idle),
    .sfr_wr      (sfr_wr),
    .sfr_addr    (sfr_addr),
    .sfr_wdata   (sfr_wdata),
    .sfr_rdata   (sfr_rdata),
    .wdt_rst_req (wdt_rst_req)
  );

  function automatic int expect_period(input int code);
    return (1 << (code + 1)) * (1 << CNT_W);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // starts at a negedge, returns at the negedge after the write edge
  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    sfr_addr  = a;
    sfr_wdata = d;
    sfr_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sfr_wr   = 1'b0;
    sfr_addr = A_WDT;
  endtask

  task automatic wait_req(inout int cnt, input int limit);
    while (!wdt_rst_req && cnt < limit) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic count_reqs(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst_req) seen++;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1: register and request while held in reset
    chk("R1 rdata in reset", int'(sfr_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", int'(sfr_rdata), 0);
    chk("R1 req after reset", int'(wdt_rst_req), 0);

    // R2: layout, reserved bits, foreign addresses
    wr_reg(A_WDT, 8'hA5);
    chk("R2 readback", int'(sfr_rdata), 8'hA5);
    wr_reg(A_WDT, 8'hBD);
    chk("R2 reserved bits read 0", int'(sfr_rdata), 8'hA5);
    sfr_addr = 8'h8E;
    #1;
    chk("R2 other address reads 0", int'(sfr_rdata), 0);
    sfr_addr = A_WDT;
    wr_reg(A_WDT, 8'h00);
    wr_reg(8'h8E, 8'h80);
    chk("R2 foreign write ignored", int'(sfr_rdata), 0);
    count_reqs(100, seen);
    chk("R2 no request after foreign write", seen, 0);

    // R3 + R4 + R7: every select code, idle-run with idle core and active core
    for (int code = 0; code < 8; code++) begin
      for (int ir = 0; ir < 2; ir++) begin
        core_idle = ir[0];
        wr_reg(A_WDT, 8'h80 | (ir << 5) | code);
        c = 0;
        wait_req(c, expect_period(code) + 20);
        chk($sformatf("R3 period code %0d idle-run %0d (R7)", code, ir), c,
            expect_period(code));
        @(negedge clk);
        chk("R4 request lasts one cycle", int'(wdt_rst_req), 0);
        chk("R4 disarmed, other fields kept", int'(sfr_rdata), (ir << 5) | code);
      end
    end
    core_idle = 1'b0;
    count_reqs(40, seen);
    chk("R4 no request once disarmed", seen, 0);

    // R7: idle pause with idle-run clear
    core_idle = 1'b1;
    wr_reg(A_WDT, 8'h80);
    c = 0;
    repeat (10) begin @(negedge clk); c++; end
    core_idle = 1'b0;
    wait_req(c, 200);
    chk("R7 idle pause adds 10", c, 42);

    // R8: tick low for seven cycles
    wr_reg(A_WDT, 8'h81);
    c = 0;
    repeat (3) begin @(negedge clk); c++; end
    tick = 1'b0;
    repeat (7) begin @(negedge clk); c++; end
    tick = 1'b1;
    wait_req(c, 300);
    chk("R8 tick gap adds 7", c, 71);

    // R9: select change mid period, ratio 16 then ratio 2
    wr_reg(A_WDT, 8'h83);
    c = 0;
    repeat (4) begin @(negedge clk); c++; end
    wr_reg(A_WDT, 8'h80);
    c++;
    wait_req(c, 400);
    chk("R9 new ratio after terminal count", c, 46);

    // R5: restart at cycle 20
    wr_reg(A_WDT, 8'h80);
    c = 0;
    repeat (19) begin @(negedge clk); c++; end
    wr_reg(A_WDT, 8'hC0);
    c++;
    chk("R5 restart bit reads 0", int'(sfr_rdata), 8'h80);
    wait_req(c, 300);
    chk("R5 restart period", c, 53);

    // R6: disarm mid count, then full period on re-arm
    wr_reg(A_WDT, 8'h80);
    repeat (10) @(negedge clk);
    wr_reg(A_WDT, 8'h00);
    count_reqs(60, seen);
    chk("R6 no request while disarmed", seen, 0);
    wr_reg(A_WDT, 8'h80);
    c = 0;
    wait_req(c, 200);
    chk("R6 full period after re-arm", c, 32);

    // R1: reset in the middle of a count
    @(negedge clk);
    wr_reg(A_WDT, 8'h80);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears register", int'(sfr_rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    count_reqs(80, seen);
    chk("R1 no request after reset", seen, 0);

    finish_run();
  end

endmodule